// File: doc/BRIEF.md
# Transmit Descriptor Poll Sequencer with Completion Interrupt Moderation

This block decides when a ring-based DMA network transmitter looks at its next transmit descriptor, and when it tells the host that frames have gone out. A programmable countdown sets the spacing of idle polls. Each poll issues a fetch request and waits for the ownership bit read from the descriptor. If the descriptor belongs to the controller, the block pulses a start request so that the data mover fills the FIFO and transmits. If the host still owns the descriptor, the countdown is reloaded and the block waits again. When a frame completes, the next descriptor is fetched at once. No poll delay is placed between frames that follow one another.

Each accepted frame completion can set a sticky transmit-done flag. The host clears the flag by writing a one to it. Two moderation controls reduce interrupt traffic. One drops the flag for every successful frame. The other drops it for successful frames that are not marked as the end of a sequence. Error completions always set the flag. The interrupt line is the flag gated by a global enable and a mask.

The sequencer has three states. ST_WAIT counts the interval down. ST_FETCH holds the fetch request. ST_XMIT means a frame is in flight. The transitions are: EXPIRE (ST_WAIT to ST_FETCH when the count is zero), OWNED (ST_FETCH to ST_XMIT on a response with the ownership bit at 1), NOT_OWNED (ST_FETCH to ST_WAIT on a response with the ownership bit at 0, which reloads the count), and END_OF_OP (ST_XMIT to ST_FETCH on a frame-done pulse). In every other case the state holds.

Top module: `txpoll_irq_ctrl`

## Requirements
- R1: While rst_n is low, desc_fetch_req, xmit_start, tx_busy, tdone_flag and tx_irq are all 0. The first rising clock edge after reset is released moves the block into ST_FETCH, so desc_fetch_req is 1 in the following cycle.
- R2: In ST_FETCH, desc_fetch_req stays 1 until desc_rsp_valid is seen. A response with desc_rsp_own=1 makes xmit_start 1 in that same cycle, for one cycle only. From the next cycle, tx_busy=1 and desc_fetch_req=0. tx_busy and desc_fetch_req are never 1 together.
- R3: A response with desc_rsp_own=0 sends the block to ST_WAIT and loads poll_interval (value P, sampled in the response cycle). desc_fetch_req is then 0 for exactly P+1 cycles and returns to 1 after that. P=0 gives one idle cycle.
- R4: A frame_done pulse while tx_busy=1 makes desc_fetch_req 1 in the next cycle, with no poll interval inserted.
- R5: frame_done while tx_busy=0 has no effect on the state or on tdone_flag. desc_rsp_valid outside ST_FETCH produces no xmit_start and no state change.
- R6: An accepted completion with frame_err=1 sets tdone_flag in the next cycle, whatever the moderation controls are.
- R7: An accepted completion with frame_err=0 sets tdone_flag only when sup_ok=0 and (last_only=0 or frame_last=1). sup_ok=1 takes priority over last_only.
- R8: A tdone_clr pulse clears tdone_flag in the next cycle. If a set and a clear happen in the same cycle, the flag ends up 1.
- R9: tx_irq equals tdone_flag AND irq_global_en AND NOT tdone_mask, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| poll_interval | input | TMR_W | Idle poll spacing P; the wait lasts P+1 cycles |
| desc_fetch_req | output | 1 | Request to read the ownership bit of the next descriptor |
| desc_rsp_valid | input | 1 | The ownership read has returned |
| desc_rsp_own | input | 1 | Ownership bit returned: 1 means the controller owns the descriptor |
| xmit_start | output | 1 | One-cycle pulse that starts FIFO fill and transmission |
| tx_busy | output | 1 | A frame is in flight |
| frame_done | input | 1 | Pulse: frame finished and its status has been written back |
| frame_err | input | 1 | The finishing frame had an error |
| frame_last | input | 1 | The finishing frame ends a sequence |
| sup_ok | input | 1 | Suppress the flag for all successful frames |
| last_only | input | 1 | Suppress the flag for successful frames that are not last |
| tdone_clr | input | 1 | Host write-one-to-clear pulse for tdone_flag |
| irq_global_en | input | 1 | Global interrupt enable |
| tdone_mask | input | 1 | Mask for the transmit-done interrupt source |
| tdone_flag | output | 1 | Sticky transmit-done status |
| tx_irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with TMR_W=4, so the poll counter has only sixteen settings. The bench sweeps every one of them, including zero and the largest value 15, and counts the idle gap after each non-owned response. The narrow width also makes it cheap to walk all 64 combinations of error, last-frame, the two moderation bits, the global enable and the mask through a real transmit cycle. Each outcome is compared with the flag and interrupt values worked out from R6, R7 and R9. Directed steps cover the set-versus-clear collision, completions and responses that arrive in the wrong state, and the reset sequence.

// File: rtl/txp_pkg.sv
package txp_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_XMIT  = 2'd2
    } txp_state_e;

    // Decide whether an accepted completion raises the transmit-done flag.
    function automatic logic txp_flag_cause(
        input logic err,
        input logic last,
        input logic sup_ok_i,
        input logic last_only_i
    );
        logic quiet;
        quiet = sup_ok_i | (last_only_i & ~last);
        return err | ~quiet;
    endfunction

endpackage

// File: rtl/txp_poll_timer.sv
module txp_poll_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);

    localparam logic [TMR_W-1:0] ZERO = '0;
    localparam logic [TMR_W-1:0] ONE  = {{(TMR_W-1){1'b0}}, 1'b1};

    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= ZERO;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != ZERO)) begin
            cnt <= cnt - ONE;
        end
    end

    assign expired = run && (cnt == ZERO);

endmodule

// File: rtl/txp_seq_fsm.sv
module txp_seq_fsm
    import txp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_expired,
    input  logic rsp_valid,
    input  logic rsp_own,
    input  logic frame_done,
    output logic fetch_req,
    output logic start_pulse,
    output logic busy,
    output logic tmr_load,
    output logic tmr_run,
    output logic done_accept
);

    txp_state_e state_q;
    txp_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (tmr_expired) begin
                    state_d = ST_FETCH;          // EXPIRE
                end
            end
            ST_FETCH: begin
                if (rsp_valid && rsp_own) begin
                    state_d = ST_XMIT;           // OWNED
                end else if (rsp_valid) begin
                    state_d = ST_WAIT;           // NOT_OWNED
                end
            end
            ST_XMIT: begin
                if (frame_done) begin
                    state_d = ST_FETCH;          // END_OF_OP
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        fetch_req   = 1'b0;
        start_pulse = 1'b0;
        busy        = 1'b0;
        tmr_load    = 1'b0;
        tmr_run     = 1'b0;
        done_accept = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                tmr_run = 1'b1;
            end
            ST_FETCH: begin
                fetch_req   = 1'b1;
                start_pulse = rsp_valid && rsp_own;
                tmr_load    = rsp_valid && !rsp_own;
            end
            ST_XMIT: begin
                busy        = 1'b1;
                done_accept = frame_done;
            end
            default: begin
                tmr_run = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/txp_irq_mod.sv
module txp_irq_mod
    import txp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done_accept,
    input  logic err,
    input  logic last,
    input  logic sup_ok,
    input  logic last_only,
    input  logic clr,
    input  logic ien,
    input  logic mask,
    output logic flag,
    output logic irq
);

    logic set_now;

    assign set_now = done_accept && txp_flag_cause(err, last, sup_ok, last_only);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_now) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && ien && !mask;

endmodule

// File: rtl/txpoll_irq_ctrl.sv
module txpoll_irq_ctrl #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] poll_interval,
    output logic             desc_fetch_req,
    input  logic             desc_rsp_valid,
    input  logic             desc_rsp_own,
    output logic             xmit_start,
    output logic             tx_busy,
    input  logic             frame_done,
    input  logic             frame_err,
    input  logic             frame_last,
    input  logic             sup_ok,
    input  logic             last_only,
    input  logic             tdone_clr,
    input  logic             irq_global_en,
    input  logic             tdone_mask,
    output logic             tdone_flag,
    output logic             tx_irq
);

    logic tmr_load;
    logic tmr_run;
    logic tmr_expired;
    logic done_accept;

    txp_poll_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .run      (tmr_run),
        .load_val (poll_interval),
        .expired  (tmr_expired)
    );

    txp_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_expired (tmr_expired),
        .rsp_valid   (desc_rsp_valid),
        .rsp_own     (desc_rsp_own),
        .frame_done  (frame_done),
        .fetch_req   (desc_fetch_req),
        .start_pulse (xmit_start),
        .busy        (tx_busy),
        .tmr_load    (tmr_load),
        .tmr_run     (tmr_run),
        .done_accept (done_accept)
    );

    txp_irq_mod u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_accept (done_accept),
        .err         (frame_err),
        .last        (frame_last),
        .sup_ok      (sup_ok),
        .last_only   (last_only),
        .clr         (tdone_clr),
        .ien         (irq_global_en),
        .mask        (tdone_mask),
        .flag        (tdone_flag),
        .irq         (tx_irq)
    );

endmodule

// File: rtl/txpoll_irq_ctrl_chk.sv
module txpoll_irq_ctrl_chk #(
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TMR_W-1:0] poll_interval,
    input logic             desc_fetch_req,
    input logic             desc_rsp_valid,
    input logic             desc_rsp_own,
    input logic             xmit_start,
    input logic             tx_busy,
    input logic             frame_done,
    input logic             frame_err,
    input logic             frame_last,
    input logic             sup_ok,
    input logic             last_only,
    input logic             tdone_clr,
    input logic             irq_global_en,
    input logic             tdone_mask,
    input logic             tdone_flag,
    input logic             tx_irq
);

    localparam int GW = TMR_W + 1;

    logic          armed;
    logic [GW-1:0] gap;
    logic [GW-1:0] ivl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            gap   <= '0;
            ivl   <= '0;
        end else if (desc_fetch_req && desc_rsp_valid && !desc_rsp_own) begin
            armed <= 1'b1;
            gap   <= '0;
            ivl   <= {1'b0, poll_interval};
        end else if (armed && !desc_fetch_req) begin
            gap <= gap + 1'b1;
        end else if (armed) begin
            armed <= 1'b0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !desc_fetch_req && !xmit_start && !tx_busy && !tdone_flag && !tx_irq); // R1

    AST_START_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_start |-> desc_fetch_req && desc_rsp_valid && desc_rsp_own); // R2

    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_start |=> tx_busy && !desc_fetch_req && !xmit_start); // R2

    AST_BUSY_FETCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_busy && desc_fetch_req)); // R2

    AST_NOT_OWNED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_fetch_req && desc_rsp_valid && !desc_rsp_own |=> !desc_fetch_req && !tx_busy); // R3

    AST_POLL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        armed && desc_fetch_req |-> gap == ivl + 1'b1); // R3

    AST_EOP_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy && frame_done |=> desc_fetch_req); // R4

    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy && frame_done && !tdone_flag |=> !tdone_flag); // R5

    AST_ERR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy && frame_done && frame_err |=> tdone_flag); // R6

    AST_SUP_OK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy && frame_done && !frame_err && sup_ok && !tdone_flag |=> !tdone_flag); // R7

    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        tdone_clr && !(tx_busy && frame_done) |=> !tdone_flag); // R8

    AST_IRQ_GATING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> tdone_flag && irq_global_en && !tdone_mask); // R9

endmodule

bind txpoll_irq_ctrl txpoll_irq_ctrl_chk #(.TMR_W(TMR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .poll_interval  (poll_interval),
    .desc_fetch_req (desc_fetch_req),
    .desc_rsp_valid (desc_rsp_valid),
    .desc_rsp_own   (desc_rsp_own),
    .xmit_start     (xmit_start),
    .tx_busy        (tx_busy),
    .frame_done     (frame_done),
    .frame_err      (frame_err),
    .frame_last     (frame_last),
    .sup_ok         (sup_ok),
    .last_only      (last_only),
    .tdone_clr      (tdone_clr),
    .irq_global_en  (irq_global_en),
    .tdone_mask     (tdone_mask),
    .tdone_flag     (tdone_flag),
    .tx_irq         (tx_irq)
);

// File: tb/txpoll_irq_ctrl_test.sv
module txpoll_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 4;
    localparam int MAXP = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] poll_interval = '0;
    logic          desc_fetch_req;
    logic          desc_rsp_valid = 1'b0;
    logic          desc_rsp_own = 1'b0;
    logic          xmit_start;
    logic          tx_busy;
    logic          frame_done = 1'b0;
    logic          frame_err = 1'b0;
    logic          frame_last = 1'b0;
    logic          sup_ok = 1'b0;
    logic          last_only = 1'b0;
    logic          tdone_clr = 1'b0;
    logic          irq_global_en = 1'b0;
    logic          tdone_mask = 1'b0;
    logic          tdone_flag;
    logic          tx_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txpoll_irq_ctrl #(.TMR_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .poll_interval(poll_interval),
        .desc_fetch_req(desc_fetch_req), .desc_rsp_valid(desc_rsp_valid),
        .desc_rsp_own(desc_rsp_own), .xmit_start(xmit_start), .tx_busy(tx_busy),
        .frame_done(frame_done), .frame_err(frame_err), .frame_last(frame_last),
        .sup_ok(sup_ok), .last_only(last_only), .tdone_clr(tdone_clr),
        .irq_global_en(irq_global_en), .tdone_mask(tdone_mask),
        .tdone_flag(tdone_flag), .tx_irq(tx_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Answer the pending fetch; leaves the bench at the negedge after the response edge.
    task automatic respond(input bit own);
        desc_rsp_valid = 1'b1;
        desc_rsp_own   = own;
        #1;
        check(xmit_start == own, "R2 start pulse", int'(xmit_start), int'(own));
        tick();
        desc_rsp_valid = 1'b0;
        desc_rsp_own   = 1'b0;
        #1;
        check(tx_busy == own && !desc_fetch_req && !xmit_start, "R2 post-response state",
              int'({tx_busy, desc_fetch_req}), int'({own, 1'b0}));
    endtask

    task automatic finish_frame(input bit err, input bit last);
        frame_done = 1'b1;
        frame_err  = err;
        frame_last = last;
        tick();
        frame_done = 1'b0;
        frame_err  = 1'b0;
        frame_last = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        check(!desc_fetch_req && !xmit_start && !tx_busy && !tdone_flag && !tx_irq,
              "R1 reset outputs", int'({desc_fetch_req, xmit_start, tx_busy, tdone_flag, tx_irq}), 0);
        rst_n = 1'b1;
        #1;
        check(!desc_fetch_req, "R1 idle before first edge", int'(desc_fetch_req), 0);
        tick();
        check(desc_fetch_req, "R1 first fetch after one edge", int'(desc_fetch_req), 1);

        // R2: fetch request held while no response
        repeat (3) tick();
        check(desc_fetch_req && !tx_busy, "R2 fetch held", int'(desc_fetch_req), 1);

        // R3: sweep every interval
        for (int p = 0; p <= MAXP; p++) begin
            int gap;
            poll_interval = TW'(p);
            respond(1'b0);
            gap = 0;
            while (!desc_fetch_req && gap < 100) begin
                gap++;
                tick();
                #1;
            end
            check(gap == p + 1, "R3 poll gap", gap, p + 1);
        end

        // R5: stimulus in the wait state is ignored
        poll_interval = TW'(MAXP);
        respond(1'b0);
        frame_done     = 1'b1;
        frame_err      = 1'b1;
        desc_rsp_valid = 1'b1;
        desc_rsp_own   = 1'b1;
        #1;
        check(!xmit_start, "R5 response ignored in wait", int'(xmit_start), 0);
        tick();
        frame_done = 1'b0; frame_err = 1'b0;
        desc_rsp_valid = 1'b0; desc_rsp_own = 1'b0;
        #1;
        check(!tdone_flag && !tx_busy && !desc_fetch_req, "R5 done ignored in wait",
              int'({tdone_flag, tx_busy, desc_fetch_req}), 0);
        while (!desc_fetch_req) begin tick(); #1; end

        // R4 and R5: in transmit, a response is ignored; completion polls at once
        respond(1'b1);
        desc_rsp_valid = 1'b1;
        desc_rsp_own   = 1'b1;
        #1;
        check(!xmit_start, "R5 response ignored in transmit", int'(xmit_start), 0);
        tick();
        desc_rsp_valid = 1'b0; desc_rsp_own = 1'b0;
        #1;
        check(tx_busy, "R5 still transmitting", int'(tx_busy), 1);
        finish_frame(1'b0, 1'b0);
        check(desc_fetch_req && !tx_busy, "R4 end-of-op poll", int'(desc_fetch_req), 1);
        tdone_clr = 1'b1; tick(); tdone_clr = 1'b0; #1;

        // R6 R7 R9: all 64 moderation combinations
        for (int c = 0; c < 64; c++) begin
            bit e, l, so, lo, ie, mk, exp_f, exp_i;
            {e, l, so, lo, ie, mk} = 6'(c);
            sup_ok = so; last_only = lo; irq_global_en = ie; tdone_mask = mk;
            respond(1'b1);
            finish_frame(e, l);
            exp_f = e || !(so || (lo && !l));
            exp_i = exp_f && ie && !mk;
            if (e) check(tdone_flag == exp_f, "R6 error sets flag", int'(tdone_flag), int'(exp_f));
            else   check(tdone_flag == exp_f, "R7 moderation", int'(tdone_flag), int'(exp_f));
            check(tx_irq == exp_i, "R9 irq gating", int'(tx_irq), int'(exp_i));
            check(desc_fetch_req, "R4 poll after frame", int'(desc_fetch_req), 1);
            tdone_clr = 1'b1;
            tick();
            tdone_clr = 1'b0;
            #1;
            check(!tdone_flag && !tx_irq, "R8 clear", int'(tdone_flag), 0);
        end

        // R9: live gating of a set flag
        sup_ok = 1'b0; last_only = 1'b0;
        respond(1'b1);
        finish_frame(1'b0, 1'b0);
        irq_global_en = 1'b1; tdone_mask = 1'b0; #1;
        check(tx_irq, "R9 irq on", int'(tx_irq), 1);
        tdone_mask = 1'b1; #1;
        check(!tx_irq, "R9 masked", int'(tx_irq), 0);
        irq_global_en = 1'b0; tdone_mask = 1'b0; #1;
        check(!tx_irq, "R9 globally disabled", int'(tx_irq), 0);

        // R8: set wins over simultaneous clear
        respond(1'b1);
        tdone_clr = 1'b1;
        finish_frame(1'b1, 1'b0);
        tdone_clr = 1'b0;
        check(tdone_flag, "R8 set wins", int'(tdone_flag), 1);
        tdone_clr = 1'b1; tick(); tdone_clr = 1'b0; #1;
        respond(1'b1);
        tdone_clr = 1'b1;
        finish_frame(1'b1, 1'b1);
        tdone_clr = 1'b0;
        check(tdone_flag, "R8 set wins from clear", int'(tdone_flag), 1);

        // R7: suppressed completion does not clear an already set flag
        sup_ok = 1'b1;
        respond(1'b1);
        finish_frame(1'b0, 1'b1);
        check(tdone_flag, "R7 sticky under suppression", int'(tdone_flag), 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule